// File: doc/BRIEF.md
# SPI FIFO Status and Interrupt Unit

This block sits between a processor register bus and a serial shift engine. It holds one transmit FIFO and one receive FIFO, each eight 32-bit words. It gathers the engine's events into sticky status bits and drives a single level-sensitive interrupt line. Software loads words into the transmit FIFO and drains the receive FIFO through data registers. It watches the two occupancy counts, which are packed into one register. It acknowledges events by writing ones to the status register.

The engine pops transmit words and pushes receive words through single-cycle strobes. It also reports a busy level and three one-cycle strobes: transfer finished, transmit underflow and receive overflow. Two threshold comparisons raise status bits when the transmit FIFO runs low or the receive FIFO fills up. Any enabled sticky status bit holds the interrupt line high.

Register reads are combinational: `reg_rdata_o` is valid in the same cycle that `reg_re_i` is high. A read of the receive data register pops the FIFO on that clock edge.

Top module: `spi_fsu_top`

## Requirements
- R1: After reset the sticky status bits, the interrupt enables and both occupancy counts are 0, the threshold register reads 0x80, and `irq_o` is low.
- R2: The register offsets are: status 0x0C, interrupt enable 0x10, threshold 0x14, word count 0x18, transmit data 0x1C and receive data 0x20. Any other offset, including 0x00, 0x04 and 0x08, reads 0.
- R3: Status bit 0 always equals `eng_busy_i`, and writing to that bit has no effect on it.
- R4: Status bit 1 (done), bit 4 (transmit underflow) and bit 5 (receive overflow) are sticky. Done sets on `eng_done_i`. Underflow sets on `eng_txuf_i` or on a pop of an empty transmit FIFO. Overflow sets on `eng_rxof_i` or on a push into a full receive FIFO. Status bits 31:6 read 0.
- R5: Writing 1 to status bits 5:1 clears them, and writing 0 leaves them unchanged. If a set event arrives in the same cycle as the clear, the bit stays 1.
- R6: Status bit 2 sets whenever the transmit occupancy is less than or equal to threshold bits 3:0.
- R7: Status bit 3 sets whenever the receive occupancy is greater than or equal to threshold bits 7:4.
- R8: `irq_o` is high exactly when some status bit k+1 (k = 0..4) is set and interrupt-enable bit k is set. It follows the status bits with no added delay, so it rises on the clock edge after the event.
- R9: Each FIFO holds 8 words and returns them in write order. The word-count register reports receive occupancy in bits 3:0 and transmit occupancy in bits 7:4.
- R10: A write to transmit data while the transmit FIFO holds 8 words is discarded.
- R11: A read of receive data while the receive FIFO is empty returns 0 and changes no count. A push into a full receive FIFO is discarded.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| reg_we_i | input | 1 | Register write strobe |
| reg_re_i | input | 1 | Register read strobe |
| reg_addr_i | input | 6 | Register byte offset |
| reg_wdata_i | input | 32 | Register write data |
| reg_rdata_o | output | 32 | Register read data, combinational |
| eng_tx_pop_i | input | 1 | Engine takes the transmit head word |
| eng_tx_data_o | output | 32 | Transmit head word |
| eng_tx_empty_o | output | 1 | Transmit FIFO empty |
| eng_rx_push_i | input | 1 | Engine delivers a received word |
| eng_rx_data_i | input | 32 | Received word |
| eng_busy_i | input | 1 | Engine transfer in progress |
| eng_done_i | input | 1 | Transfer finished strobe |
| eng_txuf_i | input | 1 | Engine transmit underflow strobe |
| eng_rxof_i | input | 1 | Engine receive overflow strobe |
| irq_o | output | 1 | Level interrupt |

## Verification
A lost or corrupted FIFO pointer shows up as a wrong word on `eng_tx_data_o` or on a receive data read, and as a wrong word-count nibble. A sticky bit that drops too early, or that never clears, shows up on the next status read and on `irq_o` one edge after the event or the clear. The scoreboard compares every popped word against the order in which the words went in. This exposes a reordering or a dropped entry at the first affected word. Status reads after each event and each clear locate a faulty set or clear term within two cycles.

// File: rtl/spi_fsu_pkg.sv
`timescale 1ns/1ps
package spi_fsu_pkg;
  localparam int ADDR_W  = 6;
  localparam int DATA_W  = 32;
  localparam int FIFO_D  = 8;
  localparam int NIB_W   = 4;
  localparam int NSRC    = 5;  // sticky sources: done, txth, rxth, txuf, rxof

  localparam logic [ADDR_W-1:0] OFF_STAT = 6'h0C;
  localparam logic [ADDR_W-1:0] OFF_IEN  = 6'h10;
  localparam logic [ADDR_W-1:0] OFF_THR  = 6'h14;
  localparam logic [ADDR_W-1:0] OFF_WCNT = 6'h18;
  localparam logic [ADDR_W-1:0] OFF_TXD  = 6'h1C;
  localparam logic [ADDR_W-1:0] OFF_RXD  = 6'h20;

  localparam logic [7:0] THR_RST = 8'h80;

  typedef enum int unsigned {
    SRC_DONE = 0, SRC_TXTH = 1, SRC_RXTH = 2, SRC_TXUF = 3, SRC_RXOF = 4
  } src_e;
endpackage

// File: rtl/spi_fsu_fifo.sv
`timescale 1ns/1ps
module spi_fsu_fifo #(
  parameter int W     = 32,
  parameter int DEPTH = 8,
  parameter int CNT_W = $clog2(DEPTH + 1)
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             push_i,
  input  logic [W-1:0]     wdata_i,
  input  logic             pop_i,
  output logic [W-1:0]     rdata_o,
  output logic [CNT_W-1:0] count_o,
  output logic             full_o,
  output logic             empty_o
);
  localparam int PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam logic [PTR_W-1:0] LAST = PTR_W'(DEPTH - 1);

  logic [W-1:0]     mem [DEPTH];
  logic [PTR_W-1:0] wr_ptr, rd_ptr;
  logic [CNT_W-1:0] cnt_q;
  logic             do_push, do_pop;

  assign full_o  = (cnt_q == CNT_W'(DEPTH));
  assign empty_o = (cnt_q == '0);
  assign do_push = push_i & ~full_o;
  assign do_pop  = pop_i & ~empty_o;
  assign rdata_o = mem[rd_ptr];
  assign count_o = cnt_q;

  always_ff @(posedge clk_i) begin
    if (do_push) mem[wr_ptr] <= wdata_i;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      wr_ptr <= '0;
      rd_ptr <= '0;
      cnt_q  <= '0;
    end else begin
      if (do_push) wr_ptr <= (wr_ptr == LAST) ? '0 : wr_ptr + 1'b1;
      if (do_pop)  rd_ptr <= (rd_ptr == LAST) ? '0 : rd_ptr + 1'b1;
      case ({do_push, do_pop})
        2'b10:   cnt_q <= cnt_q + 1'b1;
        2'b01:   cnt_q <= cnt_q - 1'b1;
        default: cnt_q <= cnt_q;
      endcase
    end
  end
endmodule

// File: rtl/spi_fsu_status.sv
`timescale 1ns/1ps
module spi_fsu_status
  import spi_fsu_pkg::*;
#(
  parameter int CNT_W = 4
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [CNT_W-1:0] tx_cnt_i,
  input  logic [CNT_W-1:0] rx_cnt_i,
  input  logic [NIB_W-1:0] tx_thr_i,
  input  logic [NIB_W-1:0] rx_thr_i,
  input  logic             done_i,
  input  logic             txuf_i,
  input  logic             rxof_i,
  input  logic [NSRC-1:0]  clr_i,
  output logic [NSRC-1:0]  stat_o
);
  logic [NSRC-1:0] set_v;
  logic [NSRC-1:0] stat_q;

  always_comb begin
    set_v           = '0;
    set_v[SRC_DONE] = done_i;
    set_v[SRC_TXTH] = 32'(tx_cnt_i) <= 32'(tx_thr_i);
    set_v[SRC_RXTH] = 32'(rx_cnt_i) >= 32'(rx_thr_i);
    set_v[SRC_TXUF] = txuf_i;
    set_v[SRC_RXOF] = rxof_i;
  end

  // set beats clear so a fresh event is never lost
  for (genvar k = 0; k < NSRC; k++) begin : g_bit
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)        stat_q[k] <= 1'b0;
      else if (set_v[k])  stat_q[k] <= 1'b1;
      else if (clr_i[k])  stat_q[k] <= 1'b0;
    end
  end

  assign stat_o = stat_q;
endmodule

// File: rtl/spi_fsu_top.sv
`timescale 1ns/1ps
module spi_fsu_top
  import spi_fsu_pkg::*;
(
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              reg_we_i,
  input  logic              reg_re_i,
  input  logic [ADDR_W-1:0] reg_addr_i,
  input  logic [DATA_W-1:0] reg_wdata_i,
  output logic [DATA_W-1:0] reg_rdata_o,
  input  logic              eng_tx_pop_i,
  output logic [DATA_W-1:0] eng_tx_data_o,
  output logic              eng_tx_empty_o,
  input  logic              eng_rx_push_i,
  input  logic [DATA_W-1:0] eng_rx_data_i,
  input  logic              eng_busy_i,
  input  logic              eng_done_i,
  input  logic              eng_txuf_i,
  input  logic              eng_rxof_i,
  output logic              irq_o
);
  localparam int CNT_W = $clog2(FIFO_D + 1);

  logic [NSRC-1:0]  ien_q;
  logic [7:0]       thr_q;
  logic [NSRC-1:0]  stat_q;
  logic [CNT_W-1:0] tx_cnt, rx_cnt;
  logic             tx_full, tx_empty, rx_full, rx_empty;
  logic [DATA_W-1:0] rx_head;
  logic             hit_stat, hit_txd, hit_rxd;
  logic             tx_push, rx_pop;
  logic [NSRC-1:0]  clr_v;

  assign hit_stat = reg_we_i && (reg_addr_i == OFF_STAT);
  assign hit_txd  = reg_we_i && (reg_addr_i == OFF_TXD);
  assign hit_rxd  = reg_re_i && (reg_addr_i == OFF_RXD);
  assign tx_push  = hit_txd;
  assign rx_pop   = hit_rxd;
  assign clr_v    = hit_stat ? reg_wdata_i[NSRC:1] : '0;

  spi_fsu_fifo #(.W(DATA_W), .DEPTH(FIFO_D), .CNT_W(CNT_W)) u_txf (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .push_i  (tx_push),
    .wdata_i (reg_wdata_i),
    .pop_i   (eng_tx_pop_i),
    .rdata_o (eng_tx_data_o),
    .count_o (tx_cnt),
    .full_o  (tx_full),
    .empty_o (tx_empty)
  );

  spi_fsu_fifo #(.W(DATA_W), .DEPTH(FIFO_D), .CNT_W(CNT_W)) u_rxf (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .push_i  (eng_rx_push_i),
    .wdata_i (eng_rx_data_i),
    .pop_i   (rx_pop),
    .rdata_o (rx_head),
    .count_o (rx_cnt),
    .full_o  (rx_full),
    .empty_o (rx_empty)
  );

  spi_fsu_status #(.CNT_W(CNT_W)) u_stat (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .tx_cnt_i (tx_cnt),
    .rx_cnt_i (rx_cnt),
    .tx_thr_i (thr_q[3:0]),
    .rx_thr_i (thr_q[7:4]),
    .done_i   (eng_done_i),
    .txuf_i   (eng_txuf_i | (eng_tx_pop_i & tx_empty)),
    .rxof_i   (eng_rxof_i | (eng_rx_push_i & rx_full)),
    .clr_i    (clr_v),
    .stat_o   (stat_q)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      ien_q <= '0;
      thr_q <= THR_RST;
    end else if (reg_we_i) begin
      if (reg_addr_i == OFF_IEN) ien_q <= reg_wdata_i[NSRC-1:0];
      if (reg_addr_i == OFF_THR) thr_q <= reg_wdata_i[7:0];
    end
  end

  always_comb begin
    reg_rdata_o = '0;
    unique case (reg_addr_i)
      OFF_STAT: reg_rdata_o = DATA_W'({stat_q, eng_busy_i});
      OFF_IEN:  reg_rdata_o = DATA_W'(ien_q);
      OFF_THR:  reg_rdata_o = DATA_W'(thr_q);
      OFF_WCNT: reg_rdata_o = DATA_W'({NIB_W'(tx_cnt), NIB_W'(rx_cnt)});
      OFF_RXD:  reg_rdata_o = rx_empty ? '0 : rx_head;
      default:  reg_rdata_o = '0;
    endcase
  end

  assign eng_tx_empty_o = tx_empty;
  assign irq_o          = |(stat_q & ien_q);
endmodule

// File: rtl/spi_fsu_chk.sv
`timescale 1ns/1ps
module spi_fsu_chk
  import spi_fsu_pkg::*;
(
  input logic              clk_i,
  input logic              rst_ni,
  input logic              reg_we_i,
  input logic [ADDR_W-1:0] reg_addr_i,
  input logic [DATA_W-1:0] reg_wdata_i,
  input logic              eng_done_i,
  input logic              eng_tx_pop_i,
  input logic [NSRC-1:0]   stat_q,
  input logic [NSRC-1:0]   ien_q,
  input logic [3:0]        tx_cnt,
  input logic [3:0]        rx_cnt,
  input logic              irq_o
);
  logic clr_done;
  assign clr_done = reg_we_i && (reg_addr_i == OFF_STAT) && reg_wdata_i[1];

  AST_DONE_SETS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    eng_done_i |=> stat_q[SRC_DONE]); // R4
  AST_DONE_HOLDS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (stat_q[SRC_DONE] && !clr_done) |=> stat_q[SRC_DONE]); // R5
  AST_DONE_CLEARS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (clr_done && !eng_done_i) |=> !stat_q[SRC_DONE]); // R5
  AST_TX_NO_OVERFLOW: assert property (@(posedge clk_i) disable iff (!rst_ni)
    32'(tx_cnt) <= FIFO_D); // R9
  AST_RX_NO_OVERFLOW: assert property (@(posedge clk_i) disable iff (!rst_ni)
    32'(rx_cnt) <= FIFO_D); // R9
  AST_TX_FULL_DROP: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (reg_we_i && reg_addr_i == OFF_TXD && 32'(tx_cnt) == FIFO_D && !eng_tx_pop_i)
      |=> 32'(tx_cnt) == FIFO_D); // R10
  AST_IRQ_MASKED: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ien_q == '0) |-> !irq_o); // R8
endmodule

bind spi_fsu_top spi_fsu_chk u_chk (
  .clk_i       (clk_i),
  .rst_ni      (rst_ni),
  .reg_we_i    (reg_we_i),
  .reg_addr_i  (reg_addr_i),
  .reg_wdata_i (reg_wdata_i),
  .eng_done_i  (eng_done_i),
  .eng_tx_pop_i(eng_tx_pop_i),
  .stat_q      (stat_q),
  .ien_q       (ien_q),
  .tx_cnt      (tx_cnt),
  .rx_cnt      (rx_cnt),
  .irq_o       (irq_o)
);

// File: tb/sim_spi_fsu_top.sv
`timescale 1ns/1ps
module sim_spi_fsu_top;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        we = 0, re = 0;
  logic [5:0]  addr = '0;
  logic [31:0] wdata = '0, rdata;
  logic        tx_pop = 0, rx_push = 0;
  logic [31:0] tx_data, rx_data = '0;
  logic        tx_empty, irq;
  logic        busy = 0, done = 0, txuf = 0, rxof = 0;

  int n_chk = 0, n_fail = 0;
  bit fin = 0;
  logic [31:0] exp_q[$];

  always #10 clk = ~clk;

  spi_fsu_top u0 (
    .clk_i(clk), .rst_ni(rst_n), .reg_we_i(we), .reg_re_i(re),
    .reg_addr_i(addr), .reg_wdata_i(wdata), .reg_rdata_o(rdata),
    .eng_tx_pop_i(tx_pop), .eng_tx_data_o(tx_data), .eng_tx_empty_o(tx_empty),
    .eng_rx_push_i(rx_push), .eng_rx_data_i(rx_data), .eng_busy_i(busy),
    .eng_done_i(done), .eng_txuf_i(txuf), .eng_rxof_i(rxof), .irq_o(irq)
  );

  task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s act=0x%08h exp=0x%08h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [5:0] a, input logic [31:0] d);
    @(negedge clk); we = 1; addr = a; wdata = d;
    @(negedge clk); we = 0;
  endtask

  task automatic rd(input logic [5:0] a, output logic [31:0] d);
    @(negedge clk); re = 1; addr = a; #1 d = rdata;
    @(negedge clk); re = 0;
  endtask

  task automatic rd_chk(input logic [5:0] a, input logic [31:0] m, input logic [31:0] e, input string req);
    logic [31:0] d;
    rd(a, d);
    chk((d & m) == e, req, d & m, e);
  endtask

  task automatic pulse(ref logic s);
    @(negedge clk); s = 1;
    @(negedge clk); s = 0;
  endtask

  // driver: software writes a word, expectation queued
  task automatic tx_write(input logic [31:0] d, input bit accept);
    wr(6'h1C, d);
    if (accept) exp_q.push_back(d);
  endtask

  // monitor: engine takes a word, compared with the queue head
  task automatic eng_take(input string req);
    logic [31:0] e;
    @(negedge clk); #1;
    e = (exp_q.size() > 0) ? exp_q.pop_front() : 32'hDEAD_0000;
    chk(tx_data == e, req, tx_data, e);
    tx_pop = 1;
    @(negedge clk); tx_pop = 0;
  endtask

  task automatic eng_give(input logic [31:0] d, input bit accept);
    @(negedge clk); rx_push = 1; rx_data = d;
    @(negedge clk); rx_push = 0;
    if (accept) exp_q.push_back(d);
  endtask

  task automatic sw_drain(input string req);
    logic [31:0] d, e;
    rd(6'h20, d);
    e = (exp_q.size() > 0) ? exp_q.pop_front() : 32'h0;
    chk(d == e, req, d, e);
  endtask

  task automatic summary;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!fin) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog act=0x%08h exp=0x%08h", 0, 1);
      summary();
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    // R1 reset state
    @(negedge clk); #1 chk(irq == 0, "R1 irq", {31'b0, irq}, 0);
    rd_chk(6'h10, 32'hFFFF_FFFF, 32'h0, "R1 enable");
    rd_chk(6'h14, 32'hFFFF_FFFF, 32'h80, "R1 threshold");
    rd_chk(6'h18, 32'hFFFF_FFFF, 32'h0, "R1 word count");
    // R6: empty tx (0 <= 0) sets bit 2; all others clear
    rd_chk(6'h0C, 32'hFFFF_FFFF, 32'h04, "R1 R6 status");
    // R2 unmapped offsets read 0
    rd_chk(6'h00, 32'hFFFF_FFFF, 32'h0, "R2 off 0x00");
    rd_chk(6'h08, 32'hFFFF_FFFF, 32'h0, "R2 off 0x08");

    // R3 pending follows busy, write can not clear it
    busy = 1;
    rd_chk(6'h0C, 32'h1, 32'h1, "R3 busy");
    wr(6'h0C, 32'h1);
    rd_chk(6'h0C, 32'h1, 32'h1, "R3 write ignored");
    busy = 0;
    rd_chk(6'h0C, 32'h1, 32'h0, "R3 idle");

    // R4 R5 done sticky, write 0 no effect, write 1 clears
    pulse(done);
    rd_chk(6'h0C, 32'h2, 32'h2, "R4 done set");
    wr(6'h0C, 32'h0);
    rd_chk(6'h0C, 32'h2, 32'h2, "R5 write0");
    wr(6'h0C, 32'h2);
    rd_chk(6'h0C, 32'h2, 32'h0, "R5 w1c");
    // R5 set wins over clear in the same cycle
    @(negedge clk); we = 1; addr = 6'h0C; wdata = 32'h2; done = 1;
    @(negedge clk); we = 0; done = 0;
    rd_chk(6'h0C, 32'h2, 32'h2, "R5 set wins");

    // R8 irq mapping: enable bit 0 -> status bit 1
    @(negedge clk); #1 chk(irq == 0, "R8 masked", {31'b0, irq}, 0);
    wr(6'h10, 32'h01);
    #1 chk(irq == 1, "R8 done irq", {31'b0, irq}, 1);
    wr(6'h0C, 32'h2);
    #1 chk(irq == 0, "R8 cleared", {31'b0, irq}, 0);
    // R4 R8 underflow strobe, enable bit 3 -> status bit 4
    wr(6'h10, 32'h08);
    @(negedge clk); txuf = 1;
    @(negedge clk); txuf = 0; #1 chk(irq == 1, "R8 txuf irq edge", {31'b0, irq}, 1);
    rd_chk(6'h0C, 32'h10, 32'h10, "R4 txuf");
    wr(6'h0C, 32'h10);
    wr(6'h10, 32'h00);

    // R9 R10 tx fifo fill, ordering, full drop
    wr(6'h14, 32'h82);
    for (int i = 0; i < 8; i++) tx_write(32'hA500_0000 + i, 1);
    tx_write(32'hBAD0_BAD0, 0);
    rd_chk(6'h18, 32'hFF, 32'h80, "R9 R10 tx count");
    // R6 clear txth while count 8 > 2: stays clear
    wr(6'h0C, 32'h04);
    rd_chk(6'h0C, 32'h04, 32'h00, "R6 above thr");
    for (int i = 0; i < 6; i++) eng_take("R9 tx order");
    rd_chk(6'h18, 32'hF0, 32'h20, "R9 tx count 2");
    rd_chk(6'h0C, 32'h04, 32'h04, "R6 at thr");
    for (int i = 0; i < 2; i++) eng_take("R9 R10 tx tail");
    @(negedge clk); #1 chk(tx_empty == 1, "R9 tx empty", {31'b0, tx_empty}, 1);

    // R7 rx threshold 3
    wr(6'h14, 32'h32);
    wr(6'h0C, 32'h3E);
    for (int i = 0; i < 2; i++) eng_give(32'hC300_0000 + i, 1);
    rd_chk(6'h0C, 32'h08, 32'h00, "R7 below");
    eng_give(32'hC300_0002, 1);
    rd_chk(6'h0C, 32'h08, 32'h08, "R7 at thr");
    rd_chk(6'h18, 32'hFF, 32'h03, "R9 rx count");
    for (int i = 0; i < 3; i++) sw_drain("R9 rx order");
    // R11 empty read returns 0, count stays 0
    rd_chk(6'h20, 32'hFFFF_FFFF, 32'h0, "R11 empty read");
    rd_chk(6'h18, 32'hFF, 32'h00, "R11 count");

    // R11 R4 rx overflow drop
    wr(6'h0C, 32'h3E);
    for (int i = 0; i < 8; i++) eng_give(32'h7700_0000 + i, 1);
    eng_give(32'hBAD1_BAD1, 0);
    rd_chk(6'h18, 32'h0F, 32'h08, "R11 rx full");
    rd_chk(6'h0C, 32'h20, 32'h20, "R4 rxof");
    wr(6'h10, 32'h10);
    #1 chk(irq == 1, "R8 rxof irq", {31'b0, irq}, 1);
    for (int i = 0; i < 8; i++) sw_drain("R11 rx order");
    rd_chk(6'h20, 32'hFFFF_FFFF, 32'h0, "R11 after drain");

    fin = 1;
    summary();
    $finish;
  end
endmodule